// File: doc/BRIEF.md
# Shared-Memory Port With Hardware Lock

This block is a request/acknowledge switch that lets several processor clients share a small window of word-wide storage and one hardware lock bit. Each client presents an operation code, an address and write data, raises its request, and waits for its acknowledge. It then takes the response word and drops the request. The switch serves one client at a time. Pending storage transfers are served before pending lock operations. Within each class, the client with the lowest index is served first.

The storage holds 16-bit words. A client can write a whole word, write a single byte, or read a word. The lock supports three operations: test-and-set, clear and read. Test-and-set is atomic because the switch performs exactly one operation per grant. No other client can act between the sampling of the lock and its update.

The controller has three states:
- **IDLE** waits for any request. It moves to **SERVE** and records the winning client.
- **SERVE** lasts one cycle. It executes the granted operation, registers the response and moves to **HOLD**.
- **HOLD** drives the granted client's acknowledge. It returns to **IDLE** once that client drops its request.

Top module: `ssw_shared_port`

## Requirements
- R1: `op` encodings are as follows.
  - 0 is byte write.
  - 1 is word write.
  - 2 is word read.
  - 3 is lock test-and-set.
  - 4 is lock clear.
  - 5 is lock read.
  - 6 and 7 behave as lock read.
  - Codes 0 to 2 are the storage class. Codes 3 to 7 are the lock class.
- R2: The window covers byte addresses BASE to BASE+2*WORDS-1 (by default 246400 to 246527). A write outside the window changes no stored word. A read outside the window returns 0.
- R3: A word write replaces both bytes of the addressed word in one cycle. A word read returns the whole word, and address bit 0 is ignored for both. Any write returns 0 on `rsp_data`.
- R4: A byte write stores `wdata[7:0]` into bits 7:0 when address bit 0 is 0, or into bits 15:8 when it is 1. The other byte of the word is left unchanged.
- R5: The acknowledge behaves as follows.
  - At most one acknowledge bit is high at any time.
  - When a request is sampled in IDLE and wins arbitration, its acknowledge rises two clock edges later.
  - The acknowledge stays high while the request stays high.
  - The acknowledge falls on the edge that samples the request low.
  - Each grant completes exactly one operation.
- R6: When storage and lock requests are pending together in IDLE, a storage request is granted first.
- R7: Among pending requests of the same class, the lowest client index is granted first.
- R8: Test-and-set returns the previous lock value in `rsp_data` bit 0 (upper bits 0) and leaves the lock at 1.
- R9: Clear returns the previous lock value and leaves the lock at 0. Lock read returns the lock value and does not change it.
- R10: Synchronous reset clears the lock, drops every acknowledge and returns the controller to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cli_req | input | NCLI | Per-client request |
| cli_op | input | NCLI*3 | Per-client operation code, client i in bits 3i+2:3i |
| cli_addr | input | NCLI*AW | Per-client byte address |
| cli_wdata | input | NCLI*16 | Per-client write data |
| cli_ack | output | NCLI | Per-client acknowledge, one-hot or zero |
| rsp_data | output | 16 | Response word, valid while an acknowledge is high |

## Verification
A wrong grant register or a wrong state shows up at the ports within two edges. It appears as an acknowledge on the wrong client, in the wrong cycle, or held after its request fell. The reference model therefore compares the acknowledge vector on every cycle.

A corrupted lock bit or stored byte stays hidden until a later lock operation or read returns it. For this reason the bench reads back every corner it has touched: written bytes, out-of-window aliases, and the lock after reset and after contention.

// File: rtl/ssw_pkg.sv
package ssw_pkg;

    localparam int OPW = 3;
    localparam int DW  = 16;
    localparam int BW  = 8;

    localparam logic [OPW-1:0] OP_BWR  = 3'd0;
    localparam logic [OPW-1:0] OP_WWR  = 3'd1;
    localparam logic [OPW-1:0] OP_WRD  = 3'd2;
    localparam logic [OPW-1:0] OP_LTAS = 3'd3;
    localparam logic [OPW-1:0] OP_LCLR = 3'd4;
    localparam logic [OPW-1:0] OP_LRD  = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_HOLD  = 2'd2
    } state_t;

    function automatic logic is_mem_op(input logic [OPW-1:0] op);
        return op <= OP_WRD;
    endfunction

endpackage

// File: rtl/ssw_arbiter.sv
module ssw_arbiter #(
    parameter int NCLI = 4,
    parameter int IW   = 2
) (
    input  logic [NCLI-1:0] req,
    input  logic [NCLI-1:0] mem_mask,
    output logic            any,
    output logic [IW-1:0]   pick
);
    logic [NCLI-1:0] mem_req;
    logic [NCLI-1:0] pool;

    always_comb begin
        mem_req = req & mem_mask;
        pool    = (|mem_req) ? mem_req : req;
        any     = |req;
        pick    = '0;
        // scan downward so the lowest set index is the last one written
        for (int i = NCLI - 1; i >= 0; i--) begin
            if (pool[i]) pick = IW'(i);
        end
    end
endmodule

// File: rtl/ssw_store.sv
module ssw_store #(
    parameter int AW    = 18,
    parameter int BASE  = 246400,
    parameter int WORDS = 64
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          byte_mode,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic          in_win,
    output logic [15:0]   rd_word
);
    localparam int          WIW = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [AW:0] LO  = (AW+1)'(BASE);
    localparam logic [AW:0] HI  = (AW+1)'(BASE + 2 * WORDS);

    logic [AW-1:0]  offs;
    logic [WIW-1:0] idx;

    assign in_win = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
    assign offs   = addr - AW'(BASE);
    assign idx    = offs[WIW:1];

    for (genvar b = 0; b < 2; b++) begin : g_lane
        logic [7:0] lane_mem [WORDS];
        logic       lane_we;
        logic [7:0] lane_src;

        assign lane_we  = wr_en && in_win && (!byte_mode || (addr[0] == 1'(b)));
        assign lane_src = byte_mode ? wdata[7:0] : wdata[b*8 +: 8];

        always_ff @(posedge clk) begin
            if (lane_we) lane_mem[idx] <= lane_src;
        end

        assign rd_word[b*8 +: 8] = in_win ? lane_mem[idx] : 8'h00;
    end
endmodule

// File: rtl/ssw_lock.sv
module ssw_lock
    import ssw_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           fire,
    input  logic [OPW-1:0] op,
    output logic           lock_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (fire) begin
            if (op == OP_LTAS)      lock_q <= 1'b1;
            else if (op == OP_LCLR) lock_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ssw_shared_port.sv
module ssw_shared_port
    import ssw_pkg::*;
#(
    parameter int NCLI  = 4,
    parameter int AW    = 18,
    parameter int BASE  = 246400,
    parameter int WORDS = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCLI-1:0]     cli_req,
    input  logic [NCLI*OPW-1:0] cli_op,
    input  logic [NCLI*AW-1:0]  cli_addr,
    input  logic [NCLI*DW-1:0]  cli_wdata,
    output logic [NCLI-1:0]     cli_ack,
    output logic [DW-1:0]       rsp_data
);
    localparam int IW = (NCLI > 1) ? $clog2(NCLI) : 1;

    state_t          state, nxt;
    logic [IW-1:0]   gnt_q, pick;
    logic            any_req;
    logic [NCLI-1:0] mem_mask;
    logic [OPW-1:0]  gop;
    logic [AW-1:0]   gaddr;
    logic [DW-1:0]   gwd;
    logic            greq, serve, in_win, lock_q;
    logic [DW-1:0]   rd_word;

    for (genvar i = 0; i < NCLI; i++) begin : g_class
        assign mem_mask[i] = is_mem_op(cli_op[i*OPW +: OPW]);
    end

    ssw_arbiter #(.NCLI(NCLI), .IW(IW)) u_arb (
        .req      (cli_req),
        .mem_mask (mem_mask),
        .any      (any_req),
        .pick     (pick)
    );

    assign gop   = cli_op[gnt_q*OPW +: OPW];
    assign gaddr = cli_addr[gnt_q*AW +: AW];
    assign gwd   = cli_wdata[gnt_q*DW +: DW];
    assign greq  = cli_req[gnt_q];
    assign serve = (state == ST_SERVE);

    ssw_store #(.AW(AW), .BASE(BASE), .WORDS(WORDS)) u_store (
        .clk       (clk),
        .wr_en     (serve && (gop == OP_BWR || gop == OP_WWR)),
        .byte_mode (gop == OP_BWR),
        .addr      (gaddr),
        .wdata     (gwd),
        .in_win    (in_win),
        .rd_word   (rd_word)
    );

    ssw_lock u_lock (
        .clk    (clk),
        .rst    (rst),
        .fire   (serve),
        .op     (gop),
        .lock_q (lock_q)
    );

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (any_req) nxt = ST_SERVE;
            ST_SERVE: nxt = ST_HOLD;
            ST_HOLD:  if (!greq) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register and grant capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            gnt_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && any_req) gnt_q <= pick;
        end
    end

    // outputs: response word registered in SERVE, acknowledge from HOLD
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_data <= '0;
        end else if (serve) begin
            if (is_mem_op(gop)) rsp_data <= (gop == OP_WRD) ? rd_word : '0;
            else                rsp_data <= {{(DW-1){1'b0}}, lock_q};
        end
    end

    always_comb begin
        cli_ack = '0;
        if (state == ST_HOLD) cli_ack[gnt_q] = 1'b1;
    end

    logic unused_ok;
    assign unused_ok = in_win;
endmodule

// File: rtl/ssw_shared_port_chk.sv
module ssw_shared_port_chk
    import ssw_pkg::*;
#(
    parameter int NCLI = 4,
    parameter int IW   = 2
) (
    input logic                clk,
    input logic                rst,
    input logic [NCLI-1:0]     cli_req,
    input logic [NCLI*OPW-1:0] cli_op,
    input logic [NCLI-1:0]     cli_ack,
    input state_t              state,
    input logic [IW-1:0]       gnt_q,
    input logic                lock_q
);
    logic [NCLI-1:0] mem_req;
    logic [OPW-1:0]  gop;

    always_comb begin
        for (int i = 0; i < NCLI; i++) begin
            mem_req[i] = cli_req[i] && (cli_op[i*OPW +: OPW] <= OP_WRD);
        end
    end
    assign gop = cli_op[gnt_q*OPW +: OPW];

    a_r5_ack_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cli_ack));

    a_r5_ack_held: assert property (@(posedge clk) disable iff (rst)
        (|(cli_ack & cli_req)) |=> ((|cli_ack) && $stable(cli_ack)));

    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (cli_ack == '0 && !lock_q));

    a_r6_mem_first: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && (|mem_req)) |=> (state == ST_SERVE && gop <= OP_WRD));

    a_r8_tas_sets: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SERVE && gop == OP_LTAS) |=> lock_q);

    a_r9_clr_drops: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SERVE && gop == OP_LCLR) |=> !lock_q);

    a_r9_lock_quiet: assert property (@(posedge clk) disable iff (rst)
        (state != ST_SERVE) |=> $stable(lock_q));
endmodule

bind ssw_shared_port ssw_shared_port_chk #(.NCLI(NCLI), .IW(IW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cli_req (cli_req),
    .cli_op  (cli_op),
    .cli_ack (cli_ack),
    .state   (state),
    .gnt_q   (gnt_q),
    .lock_q  (lock_q)
);

// File: tb/tb_ssw_shared_port.sv
module tb_ssw_shared_port;
    localparam int NCLI  = 4;
    localparam int AW    = 18;
    localparam int BASE  = 246400;
    localparam int WORDS = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          req_b [NCLI];
    logic [2:0]    op_b  [NCLI];
    logic [AW-1:0] addr_b[NCLI];
    logic [15:0]   wd_b  [NCLI];

    logic [NCLI-1:0]    cli_req;
    logic [NCLI*3-1:0]  cli_op;
    logic [NCLI*AW-1:0] cli_addr;
    logic [NCLI*16-1:0] cli_wdata;
    logic [NCLI-1:0]    cli_ack;
    logic [15:0]        rsp_data;

    for (genvar i = 0; i < NCLI; i++) begin : g_flat
        assign cli_req[i]            = req_b[i];
        assign cli_op[i*3 +: 3]      = op_b[i];
        assign cli_addr[i*AW +: AW]  = addr_b[i];
        assign cli_wdata[i*16 +: 16] = wd_b[i];
    end

    ssw_shared_port #(.NCLI(NCLI), .AW(AW), .BASE(BASE), .WORDS(WORDS)) dut (
        .clk(clk), .rst(rst), .cli_req(cli_req), .cli_op(cli_op),
        .cli_addr(cli_addr), .cli_wdata(cli_wdata),
        .cli_ack(cli_ack), .rsp_data(rsp_data)
    );

    int compared = 0;
    int mism     = 0;
    int order_q[$];

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mism++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_phase = 0, m_gnt = 0, m_lock = 0, m_rsp = 0, m_ack = 0, w = 0;
    int m_mem[WORDS];
    bit started = 0;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_phase = 0;
            m_lock  = 0;
        end else begin
            case (m_phase)
                0: begin
                    w = -1;
                    for (int i = 0; i < NCLI; i++)
                        if (req_b[i] && op_b[i] <= 2 && w < 0) w = i;
                    for (int i = 0; i < NCLI; i++)
                        if (req_b[i] && w < 0) w = i;
                    if (w >= 0) begin
                        m_gnt   = w;
                        m_phase = 1;
                    end
                end
                1: begin
                    int o, a, d, k;
                    bit inw;
                    o   = int'(op_b[m_gnt]);
                    a   = int'(addr_b[m_gnt]);
                    d   = int'(wd_b[m_gnt]);
                    inw = (a >= BASE) && (a < BASE + 2 * WORDS);
                    k   = inw ? (a - BASE) / 2 : 0;
                    case (o)
                        0: begin
                            if (inw) begin
                                if (a % 2 == 1) m_mem[k] = (m_mem[k] & 255) | ((d & 255) << 8);
                                else            m_mem[k] = (m_mem[k] & 16'hFF00) | (d & 255);
                            end
                            m_rsp = 0;
                        end
                        1: begin
                            if (inw) m_mem[k] = d;
                            m_rsp = 0;
                        end
                        2: m_rsp = inw ? m_mem[k] : 0;
                        3: begin m_rsp = m_lock; m_lock = 1; end
                        4: begin m_rsp = m_lock; m_lock = 0; end
                        default: m_rsp = m_lock;
                    endcase
                    m_phase = 2;
                end
                default: if (!req_b[m_gnt]) m_phase = 0;
            endcase
        end
        m_ack = (m_phase == 2) ? (1 << m_gnt) : 0;
    end

    always @(negedge clk) begin
        if (started) begin
            chk("R5 ack vector vs model", int'(cli_ack), m_ack);
            if (m_ack != 0) chk("R1 rsp_data vs model", int'(rsp_data), m_rsp);
        end
    end

    // ---------------- client driver ----------------
    task automatic run_op(input int c, input int o, input int a, input int d,
                          input int hold, output int r, output int waits);
        @(negedge clk);
        op_b[c]   = 3'(o);
        addr_b[c] = AW'(a);
        wd_b[c]   = 16'(d);
        req_b[c]  = 1'b1;
        waits = 0;
        do begin
            @(negedge clk);
            waits++;
        end while (!cli_ack[c]);
        r = int'(rsp_data);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R5 ack held while req high", int'(cli_ack[c]), 1);
        end
        order_q.push_back(c);
        req_b[c] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mism++;
        compared++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
        $finish;
    end

    initial begin
        int r, wt, r0, r1, r2, r3, w0, w1, w2, w3;
        for (int i = 0; i < NCLI; i++) begin
            req_b[i] = 1'b0; op_b[i] = '0; addr_b[i] = '0; wd_b[i] = '0;
        end
        for (int i = 0; i < WORDS; i++) m_mem[i] = 0;
        repeat (3) @(negedge clk);
        chk("R10 ack clear in reset", int'(cli_ack), 0);
        rst = 1'b0;

        // R10: lock reads 0 after reset; R5 latency of 2 edges
        run_op(2, 5, BASE, 0, 0, r, wt);
        chk("R10 lock after reset", r, 0);
        chk("R5 ack latency", wt, 2);

        // fill window with word writes
        for (int i = 0; i < WORDS; i++) begin
            run_op(0, 1, BASE + 2 * i, (i * 257 + 1) & 16'hFFFF, 0, r, wt);
            if (i == 0) chk("R3 write returns 0", r, 0);
        end
        run_op(1, 2, BASE + 10, 0, 0, r, wt);
        chk("R3 word read", r, 5 * 257 + 1);
        run_op(1, 2, BASE + 11, 0, 2, r, wt);
        chk("R3 read ignores addr bit 0", r, 5 * 257 + 1);

        // R4 byte lanes
        run_op(3, 0, BASE + 14, 16'hAB, 0, r, wt);
        run_op(3, 2, BASE + 14, 0, 0, r, wt);
        chk("R4 low byte write", r, 16'h07AB);
        run_op(3, 0, BASE + 15, 16'h1CD, 0, r, wt);
        run_op(3, 2, BASE + 14, 0, 0, r, wt);
        chk("R4 high byte write", r, 16'hCDAB);

        // R2 window
        run_op(0, 1, BASE - 2, 16'h5555, 0, r, wt);
        run_op(0, 1, BASE + 2 * WORDS, 16'h6666, 0, r, wt);
        run_op(0, 2, BASE - 2, 0, 0, r, wt);
        chk("R2 read below window", r, 0);
        run_op(0, 2, BASE + 2 * WORDS, 0, 0, r, wt);
        chk("R2 read above window", r, 0);
        run_op(0, 2, BASE + 2 * (WORDS - 1), 0, 0, r, wt);
        chk("R2 last word untouched", r, ((WORDS - 1) * 257 + 1) & 16'hFFFF);
        run_op(0, 2, BASE, 0, 0, r, wt);
        chk("R2 first word untouched", r, 1);

        // R8 / R9 lock sequence
        run_op(1, 3, 0, 0, 0, r, wt);  chk("R8 first tas", r, 0);
        run_op(2, 3, 0, 0, 0, r, wt);  chk("R8 second tas", r, 1);
        run_op(0, 5, 0, 0, 0, r, wt);  chk("R9 read locked", r, 1);
        run_op(0, 6, 0, 0, 0, r, wt);  chk("R1 code 6 reads lock", r, 1);
        run_op(3, 4, 0, 0, 0, r, wt);  chk("R9 clear returns prior", r, 1);
        run_op(3, 5, 0, 0, 0, r, wt);  chk("R9 read unlocked", r, 0);
        run_op(3, 4, 0, 0, 0, r, wt);  chk("R9 clear when free", r, 0);

        // R6 / R7 contention: storage first, then lowest index
        order_q.delete();
        fork
            run_op(0, 5, 0, 0, 0, r0, w0);
            run_op(1, 3, 0, 0, 0, r1, w1);
            run_op(2, 3, 0, 0, 0, r2, w2);
            run_op(3, 1, BASE + 18, 16'hBEEF, 0, r3, w3);
        join
        chk("R6 storage served first", order_q[0], 3);
        chk("R7 lock order a", order_q[1], 0);
        chk("R7 lock order b", order_q[2], 1);
        chk("R7 lock order c", order_q[3], 2);
        chk("R8 contended tas wins", r1, 0);
        chk("R8 contended tas loses", r2, 1);

        order_q.delete();
        fork
            run_op(1, 2, BASE + 18, 0, 0, r1, w1);
            run_op(2, 1, BASE + 6, 16'h1234, 0, r2, w2);
            run_op(3, 2, BASE + 6, 0, 0, r3, w3);
        join
        chk("R7 storage order a", order_q[0], 1);
        chk("R7 storage order b", order_q[1], 2);
        chk("R7 storage order c", order_q[2], 3);
        chk("R3 contended read", r1, 16'hBEEF);
        chk("R3 read after earlier write", r3, 16'h1234);

        // R10 reset while locked
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 ack clear in reset", int'(cli_ack), 0);
        rst = 1'b0;
        run_op(0, 5, 0, 0, 0, r, wt);
        chk("R10 lock cleared by reset", r, 0);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
        $finish;
    end
endmodule